// File: doc/BRIEF.md
# Interpolating Direct Digital Synthesis Channel

This block is one channel of a direct digital synthesizer. Each time the sample strobe is asserted, a 32-bit phase accumulator advances by a programmable frequency step. A per-channel phase offset is added to the accumulator value. The top bits of the resulting phase select two neighbouring entries of a 2048-point single-cycle waveform table. The next sixteen bits blend linearly between those two entries. The blended value is then multiplied by a run-time amplitude.

The table is built inside the design at elaboration time, so no memory file is needed. It holds one period of a triangle wave. To set the output frequency, use a step of f_out × 2^32 / f_strobe. For example, 20 kHz at a 1 MHz strobe rate needs a step of 85899346.

Several channels can share one accumulator-clear signal. After a common clear their phases are aligned, and the only difference between them is their offsets. An offset of 536870912 gives 45 degrees.

Top module: `dds_core`

## Requirements
- R1: On each cycle with `strobe` high and `acc_clr` low, the accumulator becomes its old value plus `freq_inc`, modulo 2^32. With `strobe` low it holds.
- R2: `acc_clr` forces the accumulator to zero. When it coincides with `strobe`:
  - the sample taken in that cycle uses phase `0 + phase_ofs`;
  - the accumulator becomes `freq_inc`.
- R3: The lookup phase is the current accumulator value plus `phase_ofs`, modulo 2^32.
- R4: Phase bits [31:21] are the table index `i`, and bits [20:5] are the fraction `f`; bits [4:0] are unused. Table entry `t(i)` is signed 16-bit:
  - 64·i for i < 512;
  - 64·(1024−i), saturated to 32767, for 512 ≤ i < 1536;
  - 64·(i−2048) for i ≥ 1536.
- R5: The interpolated value is t(i) + floor((t(i+1) − t(i)) · f / 65536).
- R6: The neighbour of index 2047 is index 0.
- R7: `sample_out` (17-bit signed) is floor(v · `amp` / 32768), where v is the interpolated value. Its magnitude never exceeds |`amp`|.
- R8: The sample taken at strobe n appears on `sample_out` after the edge of strobe n+2. `sample_vld` is high for the one cycle following that edge. The `amp` in use is the value present at that edge.
- R9: In cycles without `strobe`, `sample_out` holds its value and `sample_vld` is low.
- R10: Synchronous `rst` has these effects:
  - the accumulator is cleared;
  - the pipeline is emptied, so the first two strobes afterwards give no valid sample;
  - `sample_out` is zeroed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | Sample enable |
| acc_clr | input | 1 | Accumulator clear |
| freq_inc | input | 32 | Phase step per strobe |
| phase_ofs | input | 32 | Phase offset |
| amp | input | 16 | Signed amplitude |
| sample_out | output | 17 | Signed scaled sample |
| sample_vld | output | 1 | One-cycle flag marking a new sample |

## Verification
The bench runs several step, offset and amplitude settings through an independent model. It also aims at the following corner cases:
- **Wrap of the neighbour index.** Index 2047 at half fraction must give −32. A design that read entry 2048, or saturated the index instead of wrapping it, gives a different value.
- **Clear on a strobe.** A design that used the pre-clear accumulator would shift every later sample by one step.
- **Clear without a strobe, and a mid-run reset.** A reset that left the pipeline full would raise `sample_vld` too early.
- **Negative amplitude and amplitude zero.** These expose rounding toward zero where flooring is required, and an unsigned multiply.

// File: rtl/dds_pkg.sv
`timescale 1ns/1ps
package dds_pkg;
    localparam int PH_W   = 32;
    localparam int IDX_W  = 11;
    localparam int FRAC_W = 16;
    localparam int SMP_W  = 16;
    localparam int AMP_W  = 16;
    localparam int TBL_N  = 1 << IDX_W;
    localparam int DROP_W = PH_W - IDX_W - FRAC_W;
    localparam int DIFF_W = SMP_W + 1;
    localparam int PROD_W = DIFF_W + FRAC_W;
    localparam int SCL_W  = SMP_W + AMP_W;
    localparam int OUT_W  = SMP_W + 1;

    typedef logic [PH_W-1:0]          phase_t;
    typedef logic signed [SMP_W-1:0]  smp_t;
    typedef logic signed [AMP_W-1:0]  amp_t;
    typedef logic signed [OUT_W-1:0]  out_t;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [FRAC_W-1:0] frac;
        logic [DROP_W-1:0] drop;
    } phase_fields_t;

    typedef struct packed {
        logic              vld;
        smp_t              s0;
        smp_t              s1;
        logic [FRAC_W-1:0] frac;
    } pair_t;

    typedef struct packed {
        logic vld;
        smp_t val;
    } interp_t;

    // One period of a triangle, computed per index at elaboration.
    function automatic smp_t tri_sample(input int i);
        int q;
        int stp;
        int v;
        int vmax;
        q    = TBL_N / 4;
        stp  = (1 << (SMP_W - 1)) / q;
        vmax = (1 << (SMP_W - 1)) - 1;
        if (i < q)          v = i * stp;
        else if (i < 3 * q) v = (2 * q - i) * stp;
        else                v = (i - TBL_N) * stp;
        if (v > vmax) v = vmax;
        return smp_t'(v);
    endfunction
endpackage

// File: rtl/dds_phase_acc.sv
`timescale 1ns/1ps
module dds_phase_acc
    import dds_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   strobe,
    input  logic   acc_clr,
    input  phase_t freq_inc,
    input  phase_t phase_ofs,
    output phase_t lookup_phase,
    output phase_t acc_o
);
    phase_t acc_q;
    phase_t base;

    // A clear in the same cycle as a strobe starts that sample from zero.
    always_comb begin
        base         = acc_clr ? '0 : acc_q;
        lookup_phase = base + phase_ofs;
    end

    always_ff @(posedge clk) begin
        if (rst)          acc_q <= '0;
        else if (strobe)  acc_q <= base + freq_inc;
        else if (acc_clr) acc_q <= '0;
    end

    assign acc_o = acc_q;
endmodule

// File: rtl/dds_wave_rom.sv
`timescale 1ns/1ps
module dds_wave_rom
    import dds_pkg::*;
(
    input  logic [IDX_W-1:0] idx_a,
    input  logic [IDX_W-1:0] idx_b,
    output smp_t             dat_a,
    output smp_t             dat_b
);
    smp_t rom [TBL_N];

    for (genvar g = 0; g < TBL_N; g++) begin : g_fill
        assign rom[g] = tri_sample(g);
    end

    assign dat_a = rom[idx_a];
    assign dat_b = rom[idx_b];
endmodule

// File: rtl/dds_lookup.sv
`timescale 1ns/1ps
module dds_lookup
    import dds_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   strobe,
    input  phase_t phase,
    output pair_t  pair_q
);
    phase_fields_t     pf;
    logic [IDX_W-1:0]  nxt_idx;
    smp_t              s0;
    smp_t              s1;

    assign pf      = phase_fields_t'(phase);
    assign nxt_idx = pf.idx + 1'b1;

    dds_wave_rom u_rom (
        .idx_a (pf.idx),
        .idx_b (nxt_idx),
        .dat_a (s0),
        .dat_b (s1)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pair_q <= '0;
        end else if (strobe) begin
            pair_q.vld  <= 1'b1;
            pair_q.s0   <= s0;
            pair_q.s1   <= s1;
            pair_q.frac <= pf.frac;
        end
    end
endmodule

// File: rtl/dds_interp.sv
`timescale 1ns/1ps
module dds_interp
    import dds_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    strobe,
    input  pair_t   pair_i,
    output interp_t interp_q
);
    logic signed [DIFF_W-1:0] diff;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] shf;
    logic signed [DIFF_W-1:0] sum;

    always_comb begin
        diff = {pair_i.s1[SMP_W-1], pair_i.s1} - {pair_i.s0[SMP_W-1], pair_i.s0};
        prod = $signed({{FRAC_W{diff[DIFF_W-1]}}, diff})
             * $signed({{DIFF_W{1'b0}}, pair_i.frac});
        shf  = prod >>> FRAC_W;
        sum  = {pair_i.s0[SMP_W-1], pair_i.s0} + shf[DIFF_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            interp_q <= '0;
        end else if (strobe) begin
            interp_q.vld <= pair_i.vld;
            interp_q.val <= sum[SMP_W-1:0];
        end
    end
endmodule

// File: rtl/dds_scale.sv
`timescale 1ns/1ps
module dds_scale
    import dds_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    strobe,
    input  interp_t interp_i,
    input  amp_t    amp,
    output out_t    out_q,
    output logic    vld_q
);
    logic signed [SCL_W-1:0] mul;
    logic signed [SCL_W-1:0] shf;

    always_comb begin
        mul = interp_i.val * amp;
        shf = mul >>> (AMP_W - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= strobe & interp_i.vld;
            if (strobe && interp_i.vld) out_q <= shf[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/dds_core.sv
`timescale 1ns/1ps
module dds_core
    import dds_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     strobe,
    input  logic                     acc_clr,
    input  logic [PH_W-1:0]          freq_inc,
    input  logic [PH_W-1:0]          phase_ofs,
    input  logic signed [AMP_W-1:0]  amp,
    output logic signed [OUT_W-1:0]  sample_out,
    output logic                     sample_vld
);
    phase_t  lookup_phase;
    phase_t  acc_now;
    pair_t   pair_q;
    interp_t interp_q;

    dds_phase_acc u_acc (
        .clk          (clk),
        .rst          (rst),
        .strobe       (strobe),
        .acc_clr      (acc_clr),
        .freq_inc     (freq_inc),
        .phase_ofs    (phase_ofs),
        .lookup_phase (lookup_phase),
        .acc_o        (acc_now)
    );

    dds_lookup u_lut (
        .clk    (clk),
        .rst    (rst),
        .strobe (strobe),
        .phase  (lookup_phase),
        .pair_q (pair_q)
    );

    dds_interp u_int (
        .clk      (clk),
        .rst      (rst),
        .strobe   (strobe),
        .pair_i   (pair_q),
        .interp_q (interp_q)
    );

    dds_scale u_scl (
        .clk      (clk),
        .rst      (rst),
        .strobe   (strobe),
        .interp_i (interp_q),
        .amp      (amp),
        .out_q    (sample_out),
        .vld_q    (sample_vld)
    );
endmodule

// File: rtl/dds_core_chk.sv
`timescale 1ns/1ps
module dds_core_chk
    import dds_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    strobe,
    input logic                    acc_clr,
    input logic [PH_W-1:0]         freq_inc,
    input logic signed [AMP_W-1:0] amp,
    input logic signed [OUT_W-1:0] sample_out,
    input logic                    sample_vld,
    input logic [PH_W-1:0]         acc_q
);
    logic [OUT_W:0] mag_out;
    logic [OUT_W:0] mag_amp_prev;
    logic signed [AMP_W-1:0] amp_prev;

    always_ff @(posedge clk) amp_prev <= amp;

    always_comb begin
        mag_out      = sample_out[OUT_W-1] ? (OUT_W+1)'(-$signed({sample_out[OUT_W-1], sample_out}))
                                           : (OUT_W+1)'({1'b0, sample_out});
        mag_amp_prev = amp_prev[AMP_W-1] ? (OUT_W+1)'(-$signed({{(OUT_W+1-AMP_W){amp_prev[AMP_W-1]}}, amp_prev}))
                                         : (OUT_W+1)'(amp_prev);
    end

    AST_ACC_STEP: assert property (@(posedge clk) disable iff (rst)
        (strobe && !acc_clr) |=> acc_q == $past(acc_q) + $past(freq_inc)); // R1

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (acc_clr && !strobe) |=> acc_q == '0); // R2

    AST_CLR_STROBE: assert property (@(posedge clk) disable iff (rst)
        (acc_clr && strobe) |=> acc_q == $past(freq_inc)); // R2

    AST_AMP_BOUND: assert property (@(posedge clk) disable iff (rst)
        sample_vld |-> mag_out <= mag_amp_prev); // R7

    AST_VLD_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        sample_vld |-> $past(strobe)); // R8

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> ($stable(sample_out) && !sample_vld)); // R9
endmodule

bind dds_core dds_core_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .acc_clr    (acc_clr),
    .freq_inc   (freq_inc),
    .amp        (amp),
    .sample_out (sample_out),
    .sample_vld (sample_vld),
    .acc_q      (acc_now)
);

// File: tb/tb_dds_core.sv
`timescale 1ns/1ps
module tb_dds_core;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               strobe = 1'b0;
    logic               acc_clr = 1'b0;
    logic [31:0]        freq_inc = '0;
    logic [31:0]        phase_ofs = '0;
    logic signed [15:0] amp = '0;
    logic signed [16:0] sample_out;
    logic               sample_vld;

    int total = 0;
    int fails = 0;

    dds_core dut (
        .clk(clk), .rst(rst), .strobe(strobe), .acc_clr(acc_clr),
        .freq_inc(freq_inc), .phase_ofs(phase_ofs), .amp(amp),
        .sample_out(sample_out), .sample_vld(sample_vld)
    );

    always #2.5 clk = ~clk;

    typedef struct packed {
        logic [31:0]        inc;
        logic [31:0]        ofs;
        logic signed [15:0] a;
        logic [7:0]         n;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{32'd85899346,  32'd0,          16'sd32767,  8'd20},
        '{32'd85899346,  32'd536870912,  16'sd16384,  8'd20},
        '{32'h0020_0000, 32'd0,          16'sd32767,  8'd12},
        '{32'h0010_0000, 32'h0000_3000,  16'sd32767,  8'd12},
        '{32'hFFE0_0000, 32'hFFF0_0000,  16'sd32767,  8'd10},
        '{32'h0733_1234, 32'h1234_5678, -16'sd16384,  8'd16},
        '{32'h0100_0000, 32'd0,          16'sd0,      8'd8},
        '{32'h3C00_0001, 32'h8000_0000, -16'sd32768,  8'd16}
    };

    // Reference model
    logic [31:0] m_acc = '0;
    longint h0 = 0, h1 = 0, h2 = 0;
    int fill = 0;

    function automatic longint tbl(input int i);
        longint v;
        if (i < 512)       v = 64 * i;
        else if (i < 1536) v = 64 * (1024 - i);
        else               v = 64 * (i - 2048);
        if (v > 32767) v = 32767;
        return v;
    endfunction

    function automatic longint interp_ref(input logic [31:0] ph);
        int i;
        longint f, a, b, p;
        i = int'(ph[31:21]);
        f = longint'(ph[20:5]);
        a = tbl(i);
        b = tbl((i + 1) % 2048);
        p = (b - a) * f;
        return a + (p >>> 16);
    endfunction

    function automatic longint scale_ref(input longint x, input longint a);
        return (x * a) >>> 15;
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input logic clr);
        logic [31:0] cur;
        @(negedge clk);
        strobe  = 1'b1;
        acc_clr = clr;
        cur   = clr ? 32'd0 : m_acc;
        m_acc = cur + freq_inc;
        h2 = h1; h1 = h0; h0 = interp_ref(cur + phase_ofs);
        fill++;
        @(negedge clk);
        strobe  = 1'b0;
        acc_clr = 1'b0;
        if (fill >= 3) begin
            chk("R8 vld", longint'(sample_vld), 1);
            chk("R1 R2 R3 R4 R5 R7 sample", longint'(sample_out), scale_ref(h2, longint'(amp)));
        end else begin
            chk("R10 vld after reset", longint'(sample_vld), 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        longint held;
        repeat (4) @(negedge clk);
        chk("R10 reset out", longint'(sample_out), 0);
        chk("R10 reset vld", longint'(sample_vld), 0);
        rst = 1'b0;

        // Vector table walk
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            freq_inc  = VECS[v].inc;
            phase_ofs = VECS[v].ofs;
            amp       = VECS[v].a;
            step(1'b1);
            for (int k = 1; k < int'(VECS[v].n); k++) step(1'b0);
        end

        // R9: idle cycles hold the output
        held = longint'(sample_out);
        repeat (2) begin
            @(negedge clk);
            chk("R9 idle vld", longint'(sample_vld), 0);
            chk("R9 idle hold", longint'(sample_out), held);
        end

        // R6: index 2047 at half fraction blends toward entry 0
        freq_inc = 32'd0; phase_ofs = 32'hFFF0_0000; amp = 16'sd32767;
        step(1'b1); step(1'b0); step(1'b0);
        chk("R6 wrap neighbour", longint'(sample_out), -32);

        // R3 R7: 45 degree offset, half amplitude
        phase_ofs = 32'd536870912; amp = 16'sd16384;
        step(1'b1); step(1'b0); step(1'b0);
        chk("R3 R7 45deg half", longint'(sample_out), 8192);

        // R4: peak entry saturates
        phase_ofs = 32'h4000_0000; amp = 16'sd32767;
        step(1'b1); step(1'b0); step(1'b0);
        chk("R4 peak", longint'(sample_out), 32766);

        // R2: clear with no strobe
        freq_inc = 32'h0020_0000; phase_ofs = 32'd0;
        step(1'b1); step(1'b0); step(1'b0); step(1'b0);
        @(negedge clk);
        acc_clr = 1'b1;
        m_acc   = 32'd0;
        @(negedge clk);
        acc_clr = 1'b0;
        chk("R2 clr no strobe vld", longint'(sample_vld), 0);
        repeat (4) step(1'b0);

        // R10: reset in the middle of a run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R10 midrun out", longint'(sample_out), 0);
        chk("R10 midrun vld", longint'(sample_vld), 0);
        rst = 1'b0;
        m_acc = 32'd0; fill = 0; h0 = 0; h1 = 0; h2 = 0;
        freq_inc = 32'h0733_1234; phase_ofs = 32'h0100_0000; amp = 16'sd20000;
        repeat (6) step(1'b0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule